// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is a bus master that pushes a byte-wide configuration image into a target FPGA through its parallel slave configuration port. Software, or an upstream DMA, gives it a start pulse and the image length in bytes. The image bytes then flow in over a valid/ready stream. The loader runs the whole power-on handshake with the target. It pulses the program line and waits for the init line to fall and then rise again. It then selects the port and clocks each byte in on a rising edge of the configuration clock.

During the transfer the loader watches the target's status lines. It stops on a data error signalled by init. It leaves the image phase early if the target reports done. When the optional busy check is on, it holds off after each byte until busy clears. After the image it deselects the port and keeps clocking all-ones filler bytes until done and init are both high. It then gives a fixed number of further clocks.

All waits are bounded. Each limit is derived from a clock-frequency parameter and a time in milliseconds. At the end the block reports one result code. The configuration clock runs at a programmable half-period counted in system clocks.

Top module: `cfg_loader`

## Requirements
- R1: After reset prog_no, cs_no, wr_no and cclk_o are high, s_ready_o and fin_o are low, and err_o is 0.
- R2: On start_i while idle, prog_no goes low. It stays low for at least PROG_NS nanoseconds of system clocks and is released only after init_ni has been seen low. If init_ni does not fall within INIT_MS, the load ends with code 1.
- R3: After prog_no is released, cs_no and wr_no go low only once init_ni is high. If init_ni stays low for INIT_MS, the load ends with code 2.
- R4: Each image byte is taken by a valid/ready handshake and driven on d_o. cclk_o then goes low for HALF_CYC cycles and high for HALF_CYC cycles, so d_o is stable at the rising edge. Bytes reach the target in stream order, exactly byte_cnt_i of them.
- R5: If init_ni is low before a byte is sent, no further byte is taken and the load ends with code 3.
- R6: If done_i is high before all bytes are sent, no further byte is taken and the block goes straight to the trailing phase.
- R7: With busy_chk_i high, the next byte is not clocked while busy_i is high. If busy_i stays high for BUSY_MS, the load ends with code 4. With busy_chk_i low, busy_i has no effect.
- R8: In the trailing phase cs_no and wr_no are high and every cclk_o rising edge carries 0xFF. Once done_i and init_ni are both high at the start of a pulse, exactly TRAIL_CLKS more pulses are given and the load ends with code 0.
- R9: If the trailing phase lasts DONE_MS without completing, the load ends with code 5.
- R10: Every load ends with a one-cycle fin_o pulse. err_o holds the code (0 ok, 1 to 5 as above) until the next load ends. In the cycle of fin_o, prog_no, cs_no and wr_no are all high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (taken only when idle) |
| byte_cnt_i | input | CNT_W | Image length in bytes, sampled with start_i |
| busy_chk_i | input | 1 | Enable the per-byte busy wait |
| s_data_i | input | 8 | Image byte stream data |
| s_valid_i | input | 1 | Stream data valid |
| s_ready_o | output | 1 | Loader can take a byte |
| prog_no | output | 1 | Target program line, active low |
| cclk_o | output | 1 | Configuration clock, idles high |
| cs_no | output | 1 | Target port select, active low |
| wr_no | output | 1 | Target write enable, active low |
| d_o | output | 8 | Configuration data bus |
| init_ni | input | 1 | Target init status, active low |
| done_i | input | 1 | Target configuration done |
| busy_i | input | 1 | Target busy |
| fin_o | output | 1 | One-cycle pulse at end of a load |
| err_o | output | 3 | Result code of the last load |

## Verification
The assertions assume that init_ni, done_i and busy_i are already synchronous to clk_i. They also assume these lines move only between clock edges, since the block has no synchronizers of its own. The bench keeps to this with a behavioural target model that updates those lines on the falling edge of the system clock. The model reacts to the observed program pulses and configuration-clock rising edges. The assertions also rely on s_ready_o never depending on s_valid_i, so the stream source in the bench can insert valid gaps freely.

// File: rtl/cfg_ld_pkg.sv
`timescale 1ns/1ps
package cfg_ld_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_REL, S_LOAD, S_CLO, S_CHI, S_BUSY, S_PCHK, S_PLO, S_PHI
  } st_e;

  typedef enum logic [2:0] {
    E_OK       = 3'd0,
    E_INIT_SET = 3'd1,
    E_INIT_REL = 3'd2,
    E_CRC      = 3'd3,
    E_BUSY     = 3'd4,
    E_DONE     = 3'd5
  } err_e;

  function automatic logic is_post(st_e s);
    return s inside {S_PCHK, S_PLO, S_PHI};
  endfunction

endpackage

// File: rtl/cfg_ld_phase.sv
`timescale 1ns/1ps
// Half-period tick for the configuration clock; restarts on clr_i.
module cfg_ld_phase #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [PW-1:0] ph_q;

  assign tick_o = (ph_q == PW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (clr_i)   ph_q <= '0;
    else if (tick_o)  ph_q <= '0;
    else              ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/cfg_ld_timer.sv
`timescale 1ns/1ps
// Saturating elapsed-cycle counter shared by all bounded waits.
module cfg_ld_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (clr_i)       cnt_o <= '0;
    else if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
  import cfg_ld_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned HALF_CYC   = 2,
  parameter int unsigned PROG_NS    = 300,
  parameter int unsigned INIT_MS    = 500,
  parameter int unsigned BUSY_MS    = 5,
  parameter int unsigned DONE_MS    = 200,
  parameter int unsigned TRAIL_CLKS = 8,
  parameter int unsigned CNT_W      = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             busy_chk_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  output logic             prog_no,
  output logic             cclk_o,
  output logic             cs_no,
  output logic             wr_no,
  output logic [7:0]       d_o,
  input  logic             init_ni,
  input  logic             done_i,
  input  logic             busy_i,
  output logic             fin_o,
  output logic [2:0]       err_o
);
  localparam longint unsigned PROG_RAW =
    (longint'(CLK_HZ) * longint'(PROG_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int unsigned PROG_CYC = (PROG_RAW == 0) ? 1 : int'(PROG_RAW);
  localparam int unsigned T_INIT = int'(longint'(CLK_HZ) * longint'(INIT_MS) / 1000);
  localparam int unsigned T_BUSY = int'(longint'(CLK_HZ) * longint'(BUSY_MS) / 1000);
  localparam int unsigned T_DONE = int'(longint'(CLK_HZ) * longint'(DONE_MS) / 1000);
  localparam int unsigned T_A    = (T_INIT > T_BUSY) ? T_INIT : T_BUSY;
  localparam int unsigned T_B    = (T_A > T_DONE) ? T_A : T_DONE;
  localparam int unsigned T_MAX  = (T_B > PROG_CYC) ? T_B : PROG_CYC;
  localparam int unsigned TW     = $clog2(T_MAX + 2);
  localparam int unsigned QW     = $clog2(TRAIL_CLKS + 1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] rem_q;
  logic [7:0]       dat_q;
  logic [QW-1:0]    qcnt_q;
  err_e             err_q, err_d;
  logic             fin_q, fin_d;
  logic             take, ld_ff, qinc;
  logic [TW-1:0]    tmr;
  logic             tick;
  logic             tmr_clr, ph_clr;
  logic             qual;

  // Shared wait timer: one run per bounded wait, the trailing phase counts as one.
  assign tmr_clr = (st_d != st_q) && !(is_post(st_d) && is_post(st_q));
  assign ph_clr  = (st_d != st_q);

  cfg_ld_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .cnt_o (tmr)
  );

  cfg_ld_phase #(.HALF_CYC(HALF_CYC)) u_ph (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ph_clr),
    .tick_o(tick)
  );

  assign s_ready_o = (st_q == S_LOAD) && (rem_q != '0) && !done_i && init_ni;
  assign take      = s_ready_o && s_valid_i;
  assign qual      = done_i && init_ni;

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    fin_d = 1'b0;
    ld_ff = 1'b0;
    qinc  = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) st_d = S_PROG;
      S_PROG: begin
        if (tmr >= TW'(PROG_CYC - 1) && !init_ni) st_d = S_REL;
        else if (tmr >= TW'(T_INIT)) begin
          st_d = S_IDLE; fin_d = 1'b1; err_d = E_INIT_SET;
        end
      end
      S_REL: begin
        if (init_ni) st_d = S_LOAD;
        else if (tmr >= TW'(T_INIT)) begin
          st_d = S_IDLE; fin_d = 1'b1; err_d = E_INIT_REL;
        end
      end
      S_LOAD: begin
        if (rem_q == '0 || done_i) begin
          st_d = S_PCHK; ld_ff = 1'b1;
        end else if (!init_ni) begin
          st_d = S_IDLE; fin_d = 1'b1; err_d = E_CRC;
        end else if (s_valid_i) st_d = S_CLO;
      end
      S_CLO: if (tick) st_d = S_CHI;
      S_CHI: if (tick) st_d = busy_chk_i ? S_BUSY : S_LOAD;
      S_BUSY: begin
        if (!busy_i) st_d = S_LOAD;
        else if (tmr >= TW'(T_BUSY)) begin
          st_d = S_IDLE; fin_d = 1'b1; err_d = E_BUSY;
        end
      end
      S_PCHK: begin
        if (qual && qcnt_q == QW'(TRAIL_CLKS)) begin
          st_d = S_IDLE; fin_d = 1'b1; err_d = E_OK;
        end else if (tmr >= TW'(T_DONE)) begin
          st_d = S_IDLE; fin_d = 1'b1; err_d = E_DONE;
        end else begin
          qinc = qual;
          st_d = S_PLO;
        end
      end
      S_PLO, S_PHI: begin
        if (tmr >= TW'(T_DONE)) begin
          st_d = S_IDLE; fin_d = 1'b1; err_d = E_DONE;
        end else if (tick) st_d = (st_q == S_PLO) ? S_PHI : S_PCHK;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      dat_q  <= 8'hFF;
      qcnt_q <= '0;
      err_q  <= E_OK;
      fin_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      fin_q <= fin_d;
      if (st_q == S_IDLE && start_i) begin
        rem_q  <= byte_cnt_i;
        qcnt_q <= '0;
      end else begin
        if (take) rem_q  <= rem_q - 1'b1;
        if (qinc) qcnt_q <= qcnt_q + 1'b1;
      end
      if (take)       dat_q <= s_data_i;
      else if (ld_ff) dat_q <= 8'hFF;
    end
  end

  assign prog_no = (st_q != S_PROG);
  assign cs_no   = !(st_q inside {S_LOAD, S_CLO, S_CHI, S_BUSY});
  assign wr_no   = !(st_q inside {S_LOAD, S_CLO, S_CHI, S_BUSY});
  assign cclk_o  = !(st_q inside {S_CLO, S_PLO});
  assign d_o     = dat_q;
  assign fin_o   = fin_q;
  assign err_o   = err_q;

  AST_PROG_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_no) && !fin_o |-> !$past(init_ni)); // R2
  AST_SEL_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(init_ni)); // R3
  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> $stable(d_o)); // R4
  AST_TAKE_THEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o && s_valid_i |=> !cclk_o && !cs_no); // R4
  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_BUSY |-> tmr <= TW'(T_BUSY)); // R7
  AST_FIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> prog_no && cs_no && wr_no); // R10
  AST_FIN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o); // R10

endmodule

// File: tb/cfg_loader_tb.sv
`timescale 1ns/1ps
module cfg_loader_tb;
  localparam int unsigned CLK_HZ = 10_000;
  localparam int unsigned CNT_W  = 24;
  localparam int unsigned TRAIL  = 8;
  localparam int unsigned PMIN   = 5;   // 500 us at 10 kHz

  typedef struct packed {
    logic [7:0] n;
    logic [7:0] k;
    logic [2:0] mode;  // 0 ok,1 no init fall,2 no init rise,3 crc,4 busy stuck,5 no done,6 early done,7 busy pulses
    logic       bchk;
    logic       gap;
    logic [2:0] code;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'd16, 8'd0, 3'd0, 1'b0, 1'b0, 3'd0},
    '{8'd12, 8'd0, 3'd0, 1'b0, 1'b1, 3'd0},
    '{8'd0,  8'd0, 3'd0, 1'b0, 1'b0, 3'd0},
    '{8'd10, 8'd0, 3'd7, 1'b1, 1'b1, 3'd0},
    '{8'd6,  8'd0, 3'd4, 1'b0, 1'b0, 3'd0},
    '{8'd6,  8'd0, 3'd4, 1'b1, 1'b0, 3'd4},
    '{8'd10, 8'd4, 3'd3, 1'b0, 1'b0, 3'd3},
    '{8'd10, 8'd3, 3'd6, 1'b0, 1'b0, 3'd0},
    '{8'd5,  8'd0, 3'd5, 1'b0, 1'b0, 3'd5},
    '{8'd5,  8'd0, 3'd1, 1'b0, 1'b0, 3'd1},
    '{8'd5,  8'd0, 3'd2, 1'b0, 1'b0, 3'd2}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_ni, start_i, busy_chk_i, s_valid_i, init_ni, done_i, busy_i;
  logic [CNT_W-1:0] byte_cnt_i;
  logic [7:0]       s_data_i, d_o;
  logic             s_ready_o, prog_no, cclk_o, cs_no, wr_no, fin_o;
  logic [2:0]       err_o;

  cfg_loader #(.CLK_HZ(CLK_HZ), .HALF_CYC(2), .PROG_NS(500_000), .TRAIL_CLKS(TRAIL),
               .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
    .busy_chk_i(busy_chk_i), .s_data_i(s_data_i), .s_valid_i(s_valid_i),
    .s_ready_o(s_ready_o), .prog_no(prog_no), .cclk_o(cclk_o), .cs_no(cs_no),
    .wr_no(wr_no), .d_o(d_o), .init_ni(init_ni), .done_i(done_i), .busy_i(busy_i),
    .fin_o(fin_o), .err_o(err_o));

  int n_chk = 0, n_bad = 0;

  function automatic logic [7:0] exp_byte(int i);
    return 8'(i * 37 + 5);
  endfunction

  // stream source
  int acc_n = 0;
  always @(posedge clk) begin
    if (start_i) acc_n <= 0;
    else if (s_ready_o && s_valid_i) acc_n <= acc_n + 1;
  end
  assign s_data_i = exp_byte(acc_n);

  // target model, updated away from the active edge
  int  mode_v = 0, n_v = 0, k_v = 0;
  bit  gap_v = 0, crc_hit = 0, stuck = 0, cclk_p = 1;
  int  cyc = 0, plow = 0, plast = 0, rel = 0, busy_cnt = 0;
  int  rise_tot = 0, cap_n = 0, cap_bad = 0, ff_bad = 0, post_rise = 0, cs_bad = 0, bviol = 0;

  always @(negedge clk) if (rst_ni) begin
    cyc++;
    s_valid_i = gap_v ? (cyc % 3 != 0) : 1'b1;
    if (!prog_no) begin
      plow++;
      if (mode_v != 1 && plow >= 2) init_ni = 1'b0;
      rel = 0;
    end else begin
      if (plow != 0) begin plast = plow; plow = 0; end
      if (!init_ni && !crc_hit && mode_v != 2) begin
        rel++;
        if (rel >= 4) init_ni = 1'b1;
      end
    end
    if (!cs_no && !init_ni && !crc_hit) cs_bad++;
    if (busy_cnt != 0) busy_cnt--;
    if (cclk_o && !cclk_p) begin
      rise_tot++;
      if (!cs_no) begin
        if (busy_i) bviol++;
        if (d_o != exp_byte(cap_n)) cap_bad++;
        cap_n++;
      end else if (d_o != 8'hFF) ff_bad++;
      if (done_i) post_rise++;
      if (mode_v == 6 && rise_tot == k_v) done_i = 1'b1;
      if ((mode_v == 0 || mode_v == 4 || mode_v == 7) && rise_tot == n_v + 2) done_i = 1'b1;
      if (mode_v == 3 && rise_tot == k_v) begin init_ni = 1'b0; crc_hit = 1; end
      if (mode_v == 4) stuck = 1;
      if (mode_v == 7) busy_cnt = 6;
    end
    busy_i = stuck || (busy_cnt != 0);
    cclk_p = cclk_o;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string code_tag(logic [2:0] c);
    case (c)
      3'd1: return "R2 code";
      3'd2: return "R3 code";
      3'd3: return "R5 code";
      3'd4: return "R7 code";
      3'd5: return "R9 code";
      default: return "R8 code";
    endcase
  endfunction

  function automatic int exp_cap(vec_t v);
    case (v.mode)
      3'd1, 3'd2: return 0;
      3'd3, 3'd6: return int'(v.k);
      3'd4:       return v.bchk ? 1 : int'(v.n);
      default:    return int'(v.n);
    endcase
  endfunction

  task automatic run_vec(vec_t v);
    int  w;
    bit  seen;
    @(posedge clk); #1;
    mode_v = int'(v.mode); n_v = int'(v.n); k_v = int'(v.k); gap_v = v.gap;
    crc_hit = 0; stuck = 0; busy_cnt = 0; init_ni = 1'b1; done_i = 1'b0; busy_i = 1'b0;
    plow = 0; plast = 0; rel = 0; rise_tot = 0; cap_n = 0; cap_bad = 0; ff_bad = 0;
    post_rise = 0; cs_bad = 0; bviol = 0;
    byte_cnt_i = CNT_W'(v.n); busy_chk_i = v.bchk; start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    seen = 0;
    for (w = 0; w < 20000 && !seen; w++) begin
      @(negedge clk);
      if (fin_o) seen = 1;
    end
    chk(seen, "R10 fin seen (watchdog)", seen, 1);
    if (!seen) return;
    chk(prog_no && cs_no && wr_no, "R10 idle at finish", {prog_no, cs_no, wr_no}, 7);
    chk(err_o == v.code, code_tag(v.code), err_o, v.code);
    chk(cap_n == exp_cap(v), v.mode == 6 ? "R6 bytes before early done" : "R4 byte count",
        cap_n, exp_cap(v));
    chk(cap_bad == 0, "R4 byte order/value", cap_bad, 0);
    chk(cs_bad == 0, "R3 select while init low", cs_bad, 0);
    if (v.mode != 1) chk(plast >= PMIN, "R2 program pulse width", plast, PMIN);
    if (v.mode == 7) chk(bviol == 0, "R7 clock during busy", bviol, 0);
    if (v.code == 3'd0) begin
      chk(post_rise == TRAIL, "R8 trailing clocks", post_rise, TRAIL);
      chk(ff_bad == 0, "R8 filler bytes", ff_bad, 0);
    end
    @(negedge clk);
    chk(!fin_o && err_o == v.code, "R10 pulse length / code held", fin_o, 0);
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; byte_cnt_i = '0; busy_chk_i = 1'b0;
    s_valid_i = 1'b0; init_ni = 1'b1; done_i = 1'b0; busy_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(prog_no && cs_no && wr_no && cclk_o, "R1 control idle", {prog_no, cs_no, wr_no, cclk_o}, 15);
    chk(!s_ready_o && !fin_o && err_o == 3'd0, "R1 status idle", {s_ready_o, fin_o, err_o}, 0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 global watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule